// File: doc/BRIEF.md
# Bus-Programmable Two-Stage Watchdog Timer

This block is a watchdog peripheral on an APB-style register bus. A down-counter steps once for each rising edge of a separate watchdog clock, but only while a clock-enable input is high and the counter is enabled. When the count is found at zero and no interrupt is pending, the block raises its interrupt and reloads the count. If software has not cleared that interrupt by the next time the count is found at zero, the block asserts its reset output, provided that reset is enabled. The reset output stays asserted until bus reset.

Every register write except a write to the lock register can be blocked. Writing one fixed 32-bit key to the lock register opens the other registers, and writing any other value closes them again. A test mode lets software drive the interrupt and reset outputs directly from a register. Read-only identification bytes occupy the top of the 4 KiB register page.

The watchdog clock and its enable are brought into the bus clock domain through a two-flop synchronizer. A rising-edge detector then turns them into single-cycle ticks. The counter, the status flags and the outputs all live in the bus clock domain.

Top module: `wdog_timer`

## Requirements
- R1: After bus reset, load (0x000) and value (0x004) read as all ones across the counter width, control (0x008) reads 0, the lock (0xC00) reads 0, and the interrupt and reset outputs are low.
- R2: Writing 0x1ACCE551 to the lock register at 0xC00 clears the lock, and writing any other value sets it. Bit 0 of a read from 0xC00 returns the lock state, with 1 meaning locked.
- R3: While the lock is set, writes to load, control, interrupt clear and test control have no effect.
- R4: A write to load (0x000) sets the reload value and, in the same cycle, the counter, which then reads back from 0x004.
- R5: Control keeps only bit 0 (count and interrupt enable) and bit 1 (reset enable), and higher bits read as 0. A 0-to-1 change of bit 0 reloads the counter from load. While bit 0 is 0 the counter holds.
- R6: With control bit 0 set, each rising edge of the watchdog clock seen while the clock enable is high lowers the counter by one. Edges seen while the enable is low leave the counter unchanged.
- R7: A tick that finds the counter at 0 while raw status is clear sets raw status (0x010, bit 0) and reloads the counter. A load of L therefore interrupts on tick L+1. Masked status (0x014, bit 0) and the interrupt output both equal raw status AND control bit 0.
- R8: A tick that finds the counter at 0 while raw status is set reloads the counter. It also asserts the reset output if control bit 1 is set. Once asserted, the reset output stays high until bus reset.
- R9: Any write to interrupt clear (0x00C) while the reset output is low clears raw status and reloads the counter. Once reset has asserted, such a write does not clear raw status.
- R10: While test control (0xF00, bit 0) is set, the interrupt output follows test output (0xF04) bit 0 and the reset output follows its bit 1. Clearing test control gives the outputs back to the counter logic.
- R11: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the PERIPH_ID parameter. Reads at 0xFF0 to 0xFFC return 0x0D, 0xF0, 0x05 and 0xB1. Every unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all state is clocked by it |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| wdog_clk_i | input | 1 | Watchdog clock, sampled as a tick source |
| wdog_clken_i | input | 1 | Watchdog clock enable |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write strobe |
| paddr_i | input | 12 | Byte address in the register page |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, zero when not selected |
| int_o | output | 1 | Watchdog interrupt |
| res_o | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with CNT_W = 8 and a distinct PERIPH_ID. The narrow counter brings a full countdown from the reset value of 0xFF within reach, and the bench checks that the first interrupt arrives on exactly tick 256. It also makes a complete sweep over reload values 0 to 7 and measures the number of ticks to each interrupt. The watchdog clock is pulsed from the bench with a known width, so each pulse adds exactly one tick and every expected count follows arithmetically from the number of pulses. Escalation to reset is run with reset enabled and with it disabled, and clearing the interrupt after reset has asserted is checked as well.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BUS_W  = 32;

  localparam logic [ADDR_W-1:0] A_LOAD = 12'h000;
  localparam logic [ADDR_W-1:0] A_VAL  = 12'h004;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h008;
  localparam logic [ADDR_W-1:0] A_CLR  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_RIS  = 12'h010;
  localparam logic [ADDR_W-1:0] A_MIS  = 12'h014;
  localparam logic [ADDR_W-1:0] A_LOCK = 12'hC00;
  localparam logic [ADDR_W-1:0] A_ITCR = 12'hF00;
  localparam logic [ADDR_W-1:0] A_ITOP = 12'hF04;
  localparam logic [6:0]        ID_PAGE = 7'h7F;  // 0xFE0..0xFFF

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
  localparam logic [31:0]      CELL_ID    = 32'hB105_F00D;  // byte 0 first

  typedef struct packed {
    logic ld;       // load register written
    logic restart;  // enable bit 0 -> 1
    logic clr;      // interrupt clear written
  } core_cmd_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[i] <= '0;
      else if (i == 0) st[i] <= d_i;
      else st[i] <= st[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter logic [31:0] PERIPH_ID = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ris_i,
  output logic [CNT_W-1:0]  load_o,
  output logic [1:0]        ctrl_o,
  output logic              lock_o,
  output logic              itcr_o,
  output logic [1:0]        itop_o,
  output core_cmd_t         cmd_o
);
  logic             wr, wr_ok;
  logic [CNT_W-1:0] load_q;
  logic [1:0]       ctrl_q, itop_q;
  logic             lock_q, itcr_q;
  logic [1:0]       id_idx;
  logic [7:0]       id_byte;

  assign wr    = psel_i & penable_i & pwrite_i;
  assign wr_ok = wr & ~lock_q;

  assign cmd_o.ld      = wr_ok && (paddr_i == A_LOAD);
  assign cmd_o.restart = wr_ok && (paddr_i == A_CTRL) && pwdata_i[0] && !ctrl_q[0];
  assign cmd_o.clr     = wr_ok && (paddr_i == A_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '1;
      ctrl_q <= '0;
      lock_q <= 1'b0;
      itcr_q <= 1'b0;
      itop_q <= '0;
    end else begin
      if (wr && paddr_i == A_LOCK) lock_q <= (pwdata_i != UNLOCK_KEY);
      if (wr_ok) begin
        unique case (paddr_i)
          A_LOAD:  load_q <= pwdata_i[CNT_W-1:0];
          A_CTRL:  ctrl_q <= pwdata_i[1:0];
          A_ITCR:  itcr_q <= pwdata_i[0];
          A_ITOP:  itop_q <= pwdata_i[1:0];
          default: ;
        endcase
      end
    end
  end

  assign id_idx  = paddr_i[3:2];
  assign id_byte = paddr_i[4] ? CELL_ID[8*id_idx +: 8] : PERIPH_ID[8*id_idx +: 8];

  always_comb begin
    prdata_o = '0;
    if (psel_i) begin
      unique case (paddr_i)
        A_LOAD:  prdata_o = BUS_W'(load_q);
        A_VAL:   prdata_o = BUS_W'(cnt_i);
        A_CTRL:  prdata_o = BUS_W'(ctrl_q);
        A_RIS:   prdata_o = BUS_W'(ris_i);
        A_MIS:   prdata_o = BUS_W'(ris_i & ctrl_q[0]);
        A_LOCK:  prdata_o = BUS_W'(lock_q);
        A_ITCR:  prdata_o = BUS_W'(itcr_q);
        default:
          if (paddr_i[11:5] == ID_PAGE && paddr_i[1:0] == 2'b00)
            prdata_o = BUS_W'(id_byte);
      endcase
    end
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;
  assign lock_o = lock_q;
  assign itcr_o = itcr_q;
  assign itop_o = itop_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             res_en_i,
  input  core_cmd_t        cmd_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ris_o,
  output logic             res_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ris_q, res_q, clr_ok;

  assign clr_ok = cmd_i.clr & ~res_q;

  // priority: load write > enable restart > clear > tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      ris_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      if (clr_ok) ris_q <= 1'b0;
      if (cmd_i.ld) begin
        cnt_q <= ld_data_i;
      end else if (cmd_i.restart || clr_ok) begin
        cnt_q <= load_i;
      end else if (tick_i && en_i) begin
        if (cnt_q == '0) begin
          cnt_q <= load_i;
          if (ris_q) res_q <= res_q | res_en_i;
          else       ris_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ris_o = ris_q;
  assign res_o = res_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] PERIPH_ID   = 32'h0018_1805
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdog_clk_i,
  input  logic              wdog_clken_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  output logic              int_o,
  output logic              res_o
);
  logic [1:0]       wck_s;
  logic             wck_prev, tick;
  logic [CNT_W-1:0] cnt, load_q;
  logic [1:0]       ctrl, itop;
  logic             ris, res, lock, itcr;
  core_cmd_t        cmd;

  wdog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wdog_clken_i, wdog_clk_i}),
    .q_o   (wck_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wck_prev <= 1'b0;
    else         wck_prev <= wck_s[0];
  end

  assign tick = wck_s[0] & ~wck_prev & wck_s[1];

  wdog_regs #(.CNT_W(CNT_W), .PERIPH_ID(PERIPH_ID)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .cnt_i    (cnt),
    .ris_i    (ris),
    .load_o   (load_q),
    .ctrl_o   (ctrl),
    .lock_o   (lock),
    .itcr_o   (itcr),
    .itop_o   (itop),
    .cmd_o    (cmd)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .en_i     (ctrl[0]),
    .res_en_i (ctrl[1]),
    .cmd_i    (cmd),
    .ld_data_i(pwdata_i[CNT_W-1:0]),
    .load_i   (load_q),
    .cnt_o    (cnt),
    .ris_o    (ris),
    .res_o    (res)
  );

  assign int_o = itcr ? itop[0] : (ris & ctrl[0]);
  assign res_o = itcr ? itop[1] : res;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [BUS_W-1:0]  pwdata_i,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic [1:0]        ctrl,
  input logic              ris,
  input logic              res,
  input logic              lock
);
  logic wr;
  assign wr = psel_i & penable_i & pwrite_i;

  p_key_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && paddr_i == A_LOCK && pwdata_i == UNLOCK_KEY |=> !lock);

  p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && lock && paddr_i != A_LOCK |=> $stable(load_q) && $stable(ctrl));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr && !tick |=> $stable(cnt));

  p_flag_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ris) |-> $past(cnt) == '0);

  p_res_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res |=> res);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !lock && paddr_i == A_CLR && !res |=> !ris);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .pwdata_i (pwdata_i),
  .tick     (tick),
  .cnt      (cnt),
  .load_q   (load_q),
  .ctrl     (ctrl),
  .ris      (ris),
  .res      (res),
  .lock     (lock)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int unsigned CNT_W = 8;
  localparam logic [31:0] PID   = 32'h4B3A_2918;
  localparam logic [31:0] CID   = 32'hB105_F00D;
  localparam logic [31:0] KEY   = 32'h1ACC_E551;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wck = 1'b0, wen = 1'b0;
  logic        psel = 1'b0, pen = 1'b0, pwr = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        int_o, res_o;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .PERIPH_ID(PID)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wdog_clk_i(wck), .wdog_clken_i(wen),
    .psel_i(psel), .penable_i(pen), .pwrite_i(pwr), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .int_o(int_o), .res_o(res_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwr = 1; paddr = a; pwdata = d;
    @(negedge clk); pen = 1;
    @(negedge clk); psel = 0; pen = 0; pwr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwr = 0; paddr = a;
    @(negedge clk); pen = 1; #1 d = prdata;
    @(negedge clk); psel = 0; pen = 0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wck = 1;
      repeat (3) @(negedge clk);
      wck = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic ticks_to_int(input int cap, output int n);
    n = 0;
    while (!int_o && n < cap) begin
      pulse(1);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state
    rdchk("R1 load", 12'h000, 32'hFF);
    rdchk("R1 value", 12'h004, 32'hFF);
    rdchk("R1 ctrl", 12'h008, 32'h0);
    rdchk("R1 lock", 12'hC00, 32'h0);
    check("R1 int", {31'b0, int_o}, 0);
    check("R1 res", {31'b0, res_o}, 0);

    // R11 id bytes and unmapped addresses
    for (int i = 0; i < 4; i++) begin
      rdchk("R11 periph id", 12'hFE0 + 12'(4*i), {24'b0, PID[8*i +: 8]});
      rdchk("R11 cell id", 12'hFF0 + 12'(4*i), {24'b0, CID[8*i +: 8]});
    end
    rdchk("R11 unmapped", 12'h018, 0);
    rdchk("R11 unmapped", 12'h100, 0);
    rdchk("R11 unmapped", 12'hF04, 0);
    rdchk("R11 unmapped", 12'hFDC, 0);

    // R5 only two control bits kept
    wr(12'h008, 32'hFFFF_FFFE);
    rdchk("R5 ctrl mask", 12'h008, 32'h2);
    wr(12'h008, 0);

    // R4 load write sets counter; R5 hold while disabled
    wen = 1; repeat (4) @(negedge clk);
    wr(12'h000, 5);
    rdchk("R4 load", 12'h000, 5);
    rdchk("R4 value", 12'h004, 5);
    pulse(3);
    rdchk("R5 hold disabled", 12'h004, 5);

    // R6 enable low blocks ticks
    wen = 0; repeat (4) @(negedge clk);
    wr(12'h008, 1);
    pulse(2);
    rdchk("R6 enable low", 12'h004, 5);
    wen = 1; repeat (4) @(negedge clk);
    for (int k = 1; k <= 5; k++) begin
      pulse(1);
      rdchk("R6 step", 12'h004, 32'(5 - k));
    end
    check("R7 int before zero tick", {31'b0, int_o}, 0);
    pulse(1);
    check("R7 int", {31'b0, int_o}, 1);
    rdchk("R7 ris", 12'h010, 1);
    rdchk("R7 mis", 12'h014, 1);
    rdchk("R7 reload", 12'h004, 5);

    // R7 mask with ctrl0; R5 restart on rising edge
    pulse(2);
    wr(12'h008, 0);
    check("R7 masked int", {31'b0, int_o}, 0);
    rdchk("R7 mis masked", 12'h014, 0);
    rdchk("R7 ris kept", 12'h010, 1);
    wr(12'h008, 1);
    rdchk("R5 restart reload", 12'h004, 5);

    // R9 clear
    pulse(2);
    wr(12'h00C, 32'h0);
    check("R9 int cleared", {31'b0, int_o}, 0);
    rdchk("R9 ris cleared", 12'h010, 0);
    rdchk("R9 reload", 12'h004, 5);

    // R7 sweep: load L interrupts on tick L+1
    for (int l = 0; l < 8; l++) begin
      wr(12'h000, 32'(l));
      wr(12'h00C, 0);
      ticks_to_int(20, n);
      check("R7 ticks to int", 32'(n), 32'(l + 1));
      rdchk("R7 reload after fire", 12'h004, 32'(l));
    end

    // R8 escalation with reset disabled
    wr(12'h000, 1);
    wr(12'h00C, 0);
    pulse(4);
    check("R8 no res when disabled", {31'b0, res_o}, 0);
    rdchk("R8 reload without res", 12'h004, 1);

    // R8 escalation with reset enabled, sticky; R9 clear blocked
    wr(12'h000, 2);
    wr(12'h00C, 0);
    wr(12'h008, 3);
    pulse(3);
    check("R8 int first", {31'b0, int_o}, 1);
    check("R8 res not yet", {31'b0, res_o}, 0);
    pulse(3);
    check("R8 res asserted", {31'b0, res_o}, 1);
    wr(12'h00C, 0);
    rdchk("R9 clear blocked after res", 12'h010, 1);
    check("R8 res sticky", {31'b0, res_o}, 1);
    wr(12'h008, 1);
    pulse(3);
    check("R8 res stays", {31'b0, res_o}, 1);

    do_reset();
    check("R1 res after reset", {31'b0, res_o}, 0);
    rdchk("R1 value after reset", 12'h004, 32'hFF);

    // R2/R3 lock
    wr(12'hC00, 32'h1234_5678);
    rdchk("R2 locked", 12'hC00, 1);
    wr(12'h000, 9);
    wr(12'h008, 3);
    wr(12'hF00, 1);
    rdchk("R3 load ignored", 12'h000, 32'hFF);
    rdchk("R3 ctrl ignored", 12'h008, 0);
    rdchk("R3 itcr ignored", 12'hF00, 0);
    wr(12'hC00, KEY ^ 32'h1);
    rdchk("R2 near key locks", 12'hC00, 1);
    wr(12'hC00, KEY);
    rdchk("R2 unlocked", 12'hC00, 0);
    wr(12'h000, 9);
    rdchk("R2 write after unlock", 12'h000, 9);

    // R10 test mode sweep
    wr(12'hF00, 1);
    for (int v = 0; v < 4; v++) begin
      wr(12'hF04, 32'(v));
      check("R10 int", {31'b0, int_o}, 32'(v & 1));
      check("R10 res", {31'b0, res_o}, 32'(v >> 1));
    end
    wr(12'hF00, 0);
    check("R10 int released", {31'b0, int_o}, 0);
    check("R10 res released", {31'b0, res_o}, 0);

    // R7 full countdown from reset value
    do_reset();
    wr(12'h008, 1);
    ticks_to_int(300, n);
    check("R7 full wrap ticks", 32'(n), 256);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule